// File: doc/BRIEF.md
# Sliding-Window Image Line Cache

This block feeds a square window of 7×7 pixels, 12 bits each, to a convolution datapath. Pixels enter in raster order, one per cycle at most, over a ready/valid stream. Seven row memories, each as deep as the widest supported image, are used as a ring. The incoming row overwrites the oldest slot, and a slot pointer rotates at every row end, so the window rows always come out in top-to-bottom order.

Each accepted pixel moves the window one column to the right. The six columns already in the window registers stay, shifted one place left. Only the rightmost column is built fresh: six pixels are read from the older row slots at the current column address, and the seventh is the incoming pixel itself. The external stream therefore carries one new pixel per window step. A downstream stall holds the window and blocks the input until the window has been taken.

Top module: `sw_line_cache`

## Requirements
- R1: After reset `win_valid` is low and `in_ready` is high.
- R2: A pixel is consumed only on a rising clock edge where `in_valid` and `in_ready` are both high. In a cycle without such a transfer, `win_data` does not change.
- R3: One cycle after a transfer, cell (r, c) of the window holds the image pixel at row R-6+r and column C-6+c, where (R, C) is the zero-based position of the pixel just transferred. Cell (r, c) sits at `win_data[(r*7+c)*12 +: 12]`; r=0 is the top row and c=0 the left column.
- R4: `win_valid` goes high one cycle after a transfer whose pixel position has R ≥ 6 and C ≥ 6, counted from reset. It stays low after a transfer at any other position.
- R5: Once high, `win_valid` stays high until a cycle with `out_ready` high. After that cycle it is low, unless that same cycle also transfers a pixel that qualifies under R4.
- R6: While `win_valid` is high and `out_ready` is low, `in_ready` is low and both `win_valid` and `win_data` hold their values.
- R7: `cfg_width` sets the image width, from 7 to 1024 pixels. The column position wraps to 0, and the row position advances, after `cfg_width` transfers.
- R8: On each transfer, window columns 1 to 6 move to columns 0 to 5. The bottom-right cell takes the transferred pixel.
- R9: Window rows stay in vertical order after the row ring has wrapped, that is, beyond the seventh image row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_width | input | 11 | Image width in pixels (7..1024) |
| in_valid | input | 1 | Input pixel present |
| in_data | input | 12 | Input pixel value |
| in_ready | output | 1 | Block can take a pixel |
| out_ready | input | 1 | Downstream takes the window |
| win_valid | output | 1 | Window content is a complete 7×7 patch |
| win_data | output | 588 | 49 window cells, row-major, 12 bits each |

## Verification
The checks assume that `cfg_width` stays between 7 and 1024 and does not change between reset and the end of an image. They also assume that the image starts at reset, since the block has no frame marker. The bench follows both rules: before each scenario it sets the width while reset is asserted, and only then releases reset. Inside that frame the bench varies how pixels are offered, with idle gaps, with downstream stalls, and at the narrowest and widest widths.

// File: rtl/lc_pkg.sv
package lc_pkg;
  // Steps a ring position forward by off places, modulo n.
  function automatic int unsigned ring_step(int unsigned base, int unsigned off, int unsigned n);
    int unsigned s;
    s = base + off;
    while (s >= n) s = s - n;
    return s;
  endfunction
endpackage

// File: rtl/lc_row_store.sv
module lc_row_store #(
  parameter int PIX_W = 12,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [PIX_W-1:0] wdata,
  output logic [PIX_W-1:0] rdata
);
  logic [PIX_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  // Read before write at the same address: returns the row held in this slot
  assign rdata = mem[addr];
endmodule

// File: rtl/lc_addr_ctrl.sv
module lc_addr_ctrl #(
  parameter int WIN   = 7,
  parameter int MAX_W = 1024,
  localparam int AW   = $clog2(MAX_W),
  localparam int CW   = $clog2(MAX_W + 1),
  localparam int SW   = $clog2(WIN),
  localparam int RW   = $clog2(WIN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic [CW-1:0] cfg_width,
  output logic [AW-1:0] col,
  output logic [SW-1:0] slot,
  output logic          fill_ok
);
  logic [AW-1:0] col_q, col_d;
  logic [SW-1:0] slot_q, slot_d;
  logic [RW-1:0] rows_q, rows_d;
  logic          last_col;

  assign last_col = (CW'(col_q) == (cfg_width - CW'(1)));

  always_comb begin
    col_d  = col_q;
    slot_d = slot_q;
    rows_d = rows_q;
    if (acc) begin
      if (last_col) begin
        col_d  = '0;
        slot_d = (slot_q == SW'(WIN - 1)) ? '0 : slot_q + SW'(1);
        if (rows_q != RW'(WIN - 1)) rows_d = rows_q + RW'(1);
      end else begin
        col_d = col_q + AW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      slot_q <= '0;
      rows_q <= '0;
    end else if (acc) begin
      col_q  <= col_d;
      slot_q <= slot_d;
      rows_q <= rows_d;
    end
  end

  assign col     = col_q;
  assign slot    = slot_q;
  assign fill_ok = (rows_q == RW'(WIN - 1)) && (col_q >= AW'(WIN - 1));
endmodule

// File: rtl/lc_window_regs.sv
module lc_window_regs #(
  parameter int PIX_W = 12,
  parameter int WIN   = 7,
  localparam int CELLS = WIN * WIN
) (
  input  logic                   clk,
  input  logic                   shift,
  input  logic [WIN*PIX_W-1:0]   new_col,
  output logic [CELLS*PIX_W-1:0] win
);
  for (genvar r = 0; r < WIN; r++) begin : g_row
    for (genvar c = 0; c < WIN; c++) begin : g_col
      logic [PIX_W-1:0] cell_q, cell_d;
      if (c == WIN - 1) begin : g_in
        assign cell_d = new_col[r*PIX_W +: PIX_W];
      end else begin : g_mv
        assign cell_d = win[(r*WIN+c+1)*PIX_W +: PIX_W];
      end
      always_ff @(posedge clk) begin
        if (shift) cell_q <= cell_d;
      end
      assign win[(r*WIN+c)*PIX_W +: PIX_W] = cell_q;
    end
  end
endmodule

// File: rtl/sw_line_cache.sv
module sw_line_cache #(
  parameter int PIX_W = 12,
  parameter int WIN   = 7,
  parameter int MAX_W = 1024,
  localparam int AW   = $clog2(MAX_W),
  localparam int CW   = $clog2(MAX_W + 1),
  localparam int SW   = $clog2(WIN),
  localparam int CELLS = WIN * WIN
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [CW-1:0]          cfg_width,
  input  logic                   in_valid,
  input  logic [PIX_W-1:0]       in_data,
  output logic                   in_ready,
  input  logic                   out_ready,
  output logic                   win_valid,
  output logic [CELLS*PIX_W-1:0] win_data
);
  logic                 acc;
  logic [AW-1:0]        col;
  logic [SW-1:0]        slot;
  logic                 fill_ok;
  logic [PIX_W-1:0]     rd [WIN];
  logic [WIN*PIX_W-1:0] new_col;
  logic                 valid_q, valid_d;

  assign in_ready = !valid_q || out_ready;
  assign acc      = in_valid && in_ready;

  lc_addr_ctrl #(.WIN(WIN), .MAX_W(MAX_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .acc(acc), .cfg_width(cfg_width),
    .col(col), .slot(slot), .fill_ok(fill_ok)
  );

  for (genvar i = 0; i < WIN; i++) begin : g_rows
    lc_row_store #(.PIX_W(PIX_W), .DEPTH(MAX_W)) row_i (
      .clk(clk), .we(acc && (slot == SW'(i))), .addr(col),
      .wdata(in_data), .rdata(rd[i])
    );
  end

  // Oldest row sits in the slot after the one being written
  always_comb begin
    for (int r = 0; r < WIN - 1; r++) begin
      int unsigned idx;
      idx = lc_pkg::ring_step(int'(slot), r + 1, WIN);
      new_col[r*PIX_W +: PIX_W] = rd[idx[SW-1:0]];
    end
    new_col[(WIN-1)*PIX_W +: PIX_W] = in_data;
  end

  lc_window_regs #(.PIX_W(PIX_W), .WIN(WIN)) win_i (
    .clk(clk), .shift(acc), .new_col(new_col), .win(win_data)
  );

  always_comb begin
    if (acc)            valid_d = fill_ok;
    else if (out_ready) valid_d = 1'b0;
    else                valid_d = valid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  assign win_valid = valid_q;
endmodule

// File: rtl/sw_line_cache_chk.sv
module sw_line_cache_chk #(
  parameter int PIX_W = 12,
  parameter int WIN   = 7,
  localparam int CELLS = WIN * WIN
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic [PIX_W-1:0]       in_data,
  input logic                   in_ready,
  input logic                   out_ready,
  input logic                   win_valid,
  input logic [CELLS*PIX_W-1:0] win_data
);
  logic                   xfer;
  logic [CELLS*PIX_W-1:0] moved, kept;

  assign xfer = in_valid && in_ready;

  always_comb begin
    for (int r = 0; r < WIN; r++) begin
      for (int c = 0; c < WIN; c++) begin
        if (c == WIN - 1) begin
          moved[(r*WIN+c)*PIX_W +: PIX_W] = '0;
          kept[(r*WIN+c)*PIX_W +: PIX_W]  = '0;
        end else begin
          moved[(r*WIN+c)*PIX_W +: PIX_W] = win_data[(r*WIN+c+1)*PIX_W +: PIX_W];
          kept[(r*WIN+c)*PIX_W +: PIX_W]  = win_data[(r*WIN+c)*PIX_W +: PIX_W];
        end
      end
    end
  end

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && !out_ready) |=> (win_valid && $stable(win_data)));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> $stable(win_data));

  // R5
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && out_ready && !xfer) |=> !win_valid);

  // R4
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_valid) |-> $past(xfer));

  // R8
  col_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> (kept == $past(moved)));

  // R8
  newest_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> (win_data[(CELLS-1)*PIX_W +: PIX_W] == $past(in_data)));
endmodule

bind sw_line_cache sw_line_cache_chk #(.PIX_W(PIX_W), .WIN(WIN)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
  .in_ready(in_ready), .out_ready(out_ready), .win_valid(win_valid),
  .win_data(win_data)
);

// File: tb/sw_line_cache_tb.sv
module sw_line_cache_tb_top;
  localparam int PW = 12;
  localparam int W  = 7;
  localparam int NB = W * W * PW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [10:0]   cfg_width;
  logic          in_valid;
  logic [PW-1:0] in_data;
  logic          in_ready;
  logic          out_ready;
  logic          win_valid;
  logic [NB-1:0] win_data;

  int checks = 0;
  int bad    = 0;

  always #4 clk = ~clk;

  sw_line_cache dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .out_ready(out_ready),
    .win_valid(win_valid), .win_data(win_data)
  );

  function automatic logic [PW-1:0] pix(int r, int c, int seed);
    return PW'((r * 97 + c * 13 + seed * 211) & 4095);
  endfunction

  function automatic logic [NB-1:0] exp_win(int rr, int cc, int seed);
    logic [NB-1:0] v;
    for (int r = 0; r < W; r++)
      for (int c = 0; c < W; c++)
        v[(r*W+c)*PW +: PW] = pix(rr - 6 + r, cc - 6 + c, seed);
    return v;
  endfunction

  task automatic chk_bit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic chk_win(string req, logic [NB-1:0] act, logic [NB-1:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(int width);
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_data   = '0;
    out_ready = 1'b1;
    cfg_width = 11'(width);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Sends one pixel with out_ready high and checks the window one cycle later
  task automatic send_pixel(int r, int c, int seed, string req);
    in_valid = 1'b1;
    in_data  = pix(r, c, seed);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk_bit({"R4 ", req}, win_valid, (r >= 6) && (c >= 6));
    if (r >= 6 && c >= 6) chk_win({"R3 ", req}, win_data, exp_win(r, c, seed));
  endtask

  task automatic t_reset();
    do_reset(7);
    chk_bit("R1 valid", win_valid, 1'b0);
    chk_bit("R1 ready", in_ready, 1'b1);
  endtask

  // Narrowest width, ring wraps after row 7 (R7, R9)
  task automatic t_min_width();
    do_reset(7);
    for (int r = 0; r < 10; r++)
      for (int c = 0; c < 7; c++) send_pixel(r, c, 1, "R7 R9 w7");
  endtask

  // Idle gaps: window unchanged and valid released (R2, R5)
  task automatic t_gaps();
    logic [NB-1:0] held;
    do_reset(12);
    for (int r = 0; r < 9; r++)
      for (int c = 0; c < 12; c++) begin
        send_pixel(r, c, 2, "R2 gaps");
        if ((c % 3) == 1) begin
          held = win_data;
          @(posedge clk);
          @(negedge clk);
          chk_bit("R5 drop after idle", win_valid, 1'b0);
          chk_win("R2 idle hold", win_data, held);
        end
      end
  endtask

  // Downstream stall holds window and blocks input (R6, R5)
  task automatic t_stall();
    do_reset(8);
    for (int r = 0; r < 6; r++)
      for (int c = 0; c < 8; c++) send_pixel(r, c, 3, "R6 fill");
    for (int c = 0; c < 7; c++) send_pixel(6, c, 3, "R6 fill");
    out_ready = 1'b0;
    in_valid  = 1'b1;
    in_data   = pix(6, 7, 3);
    #1;
    chk_bit("R6 ready low", in_ready, 1'b0);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk_bit("R6 valid held", win_valid, 1'b1);
      chk_win("R6 window held", win_data, exp_win(6, 6, 3));
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk_bit("R5 valid new", win_valid, 1'b1);
    chk_win("R6 after release", win_data, exp_win(6, 7, 3));
    @(posedge clk);
    @(negedge clk);
    chk_bit("R5 valid consumed", win_valid, 1'b0);
  endtask

  // Widest width (R7)
  task automatic t_max_width();
    do_reset(1024);
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 1024; c++) send_pixel(r, c, 4, "R7 w1024");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_min_width();
    t_gaps();
    t_stall();
    t_max_width();
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule